// File: doc/BRIEF.md
# Flash Query Response Formatter

This block sits between a parallel-flash bus front end and the query and identifier data of a flash bank. The bank is built from several identical devices wired side by side. The front end presents a bus byte offset and selects either a query-table read or an identifier read. The block turns the offset into an entry index and drives that index out to an external table store. In the same cycle it takes back the table byte. One cycle after the request it delivers a response word in which every device lane of the bank carries that device's answer.

Three parameters shape the block, each 1, 2 or 4 bytes: the bank width, the width at which each device is run, and the widest mode the device supports. All index shifting and lane copying is resolved from these at elaboration. The block supplies the fixed signature header of the query table itself. Every other table entry comes from the external store.

Top module: `flash_query_fmt`

## Requirements
- R1: `index_o` equals `offset_i` shifted right by log2(BANK_W) + log2(MAX_DEV_W) − log2(DEV_W), combinationally in the request cycle; the default configuration (4, 1, 2) gives a shift of 3.
- R2: A request with `req_valid_i` high on a rising clock edge produces `resp_valid_o` high for exactly the following cycle, with `resp_o` holding the response; without a request `resp_valid_o` is low. After reset `resp_valid_o` and `resp_o` are zero.
- R3: A query read (`req_is_id_i` low) whose index is 0x52 or greater returns an all-zero word.
- R4: For query indices 0x10, 0x11, 0x12, 0x13 and 0x14 the per-device byte is 0x51, 0x52, 0x59, 0x01 and 0x00 respectively, whatever `table_byte_i` carries; at any other index below 0x52 it is `table_byte_i`.
- R5: When DEV_W is 1 and MAX_DEV_W is larger, the query byte fills every byte of the device answer, so every byte lane of the bank carries it.
- R6: When DEV_W is smaller than MAX_DEV_W but not 1, every query read returns zero.
- R7: The low DEV_W bytes of the device answer are copied into each DEV_W-byte lane from byte 0 up to BANK_W bytes; bytes at and above BANK_W are zero.
- R8: An identifier read (`req_is_id_i` high) decodes only index bits [7:0]: 0 yields `mfr_code_i`, 1 yields `dev_code_i` (16-bit codes, zero-extended to the device answer), any other value yields zero; higher index bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_is_id_i | input | 1 | 1 = identifier read, 0 = query-table read |
| offset_i | input | OFF_W | Bus byte offset |
| index_o | output | OFF_W − shift | Entry index for the external table store |
| table_byte_i | input | 8 | Table byte looked up at `index_o`, same cycle |
| mfr_code_i | input | 16 | Manufacturer code |
| dev_code_i | input | 16 | Device code |
| resp_valid_o | output | 1 | Response valid, one cycle after a request |
| resp_o | output | 32 | Replicated response word |

## Verification
Three instances run side by side on the same stimulus: the default x8 configuration, a bank of two 16-bit devices run below their 32-bit maximum, and a narrow two-byte bank of byte devices. Query reads sweep the whole table and beyond. This separates the internal header bytes from store bytes, the last valid index from the first out-of-range one, and full-lane repetition from two-lane copying with zeroed upper bytes. Identifier reads at indices 0 to 3 and at the same indices with bit 8 set show that lock-status slots read as zero and that upper index bits are ignored. Gaps between back-to-back requests test that the valid flag tracks the strobe exactly.

// File: rtl/fqr_pkg.sv
package fqr_pkg;
  localparam int unsigned QRY_TABLE_LEN = 'h52;
  localparam int unsigned HDR_FIRST     = 'h10;
  localparam int unsigned HDR_LAST      = 'h14;

  function automatic logic [7:0] hdr_byte(input logic [2:0] sel);
    case (sel)
      3'd0:    hdr_byte = 8'h51;
      3'd1:    hdr_byte = 8'h52;
      3'd2:    hdr_byte = 8'h59;
      3'd3:    hdr_byte = 8'h01;
      default: hdr_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/fqr_index.sv
module fqr_index #(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 3,
  localparam int unsigned IDX_W = OFF_W - SHIFT
) (
  input  logic [OFF_W-1:0] offset_i,
  output logic [IDX_W-1:0] index_o
);
  assign index_o = offset_i[OFF_W-1:SHIFT];
endmodule

// File: rtl/fqr_select.sv
module fqr_select #(
  parameter int unsigned IDX_W     = 13,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 2
) (
  input  logic [IDX_W-1:0] index_i,
  input  logic             is_id_i,
  input  logic [7:0]       table_byte_i,
  input  logic [15:0]      mfr_code_i,
  input  logic [15:0]      dev_code_i,
  output logic [31:0]      dev_word_o
);
  import fqr_pkg::*;

  localparam bit NARROW = (DEV_W != MAX_DEV_W);
  localparam bit QRY_OK = !NARROW || (DEV_W == 1 && BANK_W <= 4);

  logic [7:0]  q_byte;
  logic [31:0] q_word;
  logic [31:0] id_word;

  always_comb begin
    if (index_i >= IDX_W'(QRY_TABLE_LEN))
      q_byte = 8'h00;
    else if (index_i >= IDX_W'(HDR_FIRST) && index_i <= IDX_W'(HDR_LAST))
      q_byte = hdr_byte(index_i[2:0]);
    else
      q_byte = table_byte_i;
  end

  // x8 use of a wider part: byte repeated over the full native width
  always_comb begin
    q_word = '0;
    for (int b = 0; b < 4; b++)
      if (b == 0 || (NARROW && b < int'(MAX_DEV_W)))
        q_word[b*8 +: 8] = q_byte;
  end

  always_comb begin
    case (index_i[7:0])
      8'd0:    id_word = {16'h0, mfr_code_i};
      8'd1:    id_word = {16'h0, dev_code_i};
      default: id_word = '0;
    endcase
  end

  assign dev_word_o = is_id_i ? id_word : (QRY_OK ? q_word : 32'h0);
endmodule

// File: rtl/fqr_lane_rep.sv
module fqr_lane_rep #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned DEV_W  = 1
) (
  input  logic [31:0] dev_word_i,
  output logic [31:0] bank_word_o
);
  localparam int unsigned LANE_BITS = DEV_W * 8;
  localparam int unsigned N_LANES   = BANK_W / DEV_W;

  logic unused_hi;
  assign unused_hi = ^dev_word_i;

  always_comb begin
    bank_word_o = '0;
    for (int k = 0; k < int'(N_LANES); k++)
      bank_word_o[k*LANE_BITS +: LANE_BITS] = dev_word_i[LANE_BITS-1:0];
  end
endmodule

// File: rtl/flash_query_fmt.sv
module flash_query_fmt #(
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 2,
  localparam int unsigned SHIFT = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W),
  localparam int unsigned IDX_W = OFF_W - SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_is_id_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [IDX_W-1:0] index_o,
  input  logic [7:0]       table_byte_i,
  input  logic [15:0]      mfr_code_i,
  input  logic [15:0]      dev_code_i,
  output logic             resp_valid_o,
  output logic [31:0]      resp_o
);
  import fqr_pkg::*;

  localparam logic [31:0] BANK_MASK = (BANK_W == 4) ? 32'hFFFF_FFFF
                                    : ((32'd1 << (BANK_W * 8)) - 32'd1);
  localparam bit QRY_OK = (DEV_W == MAX_DEV_W) || (DEV_W == 1 && BANK_W <= 4);

  logic [31:0] dev_word;
  logic [31:0] bank_word;

  fqr_index #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_index (
    .offset_i (offset_i),
    .index_o  (index_o)
  );

  fqr_select #(
    .IDX_W(IDX_W), .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W)
  ) u_select (
    .index_i      (index_o),
    .is_id_i      (req_is_id_i),
    .table_byte_i (table_byte_i),
    .mfr_code_i   (mfr_code_i),
    .dev_code_i   (dev_code_i),
    .dev_word_o   (dev_word)
  );

  fqr_lane_rep #(.BANK_W(BANK_W), .DEV_W(DEV_W)) u_rep (
    .dev_word_i  (dev_word),
    .bank_word_o (bank_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_o       <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      if (req_valid_i) resp_o <= bank_word;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);
  assert_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> ((resp_o & ~BANK_MASK) == 32'h0));
  assert_oob_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && $past(!req_is_id_i && index_o >= IDX_W'(QRY_TABLE_LEN))
    |-> resp_o == 32'h0);
  assert_id_other_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && $past(req_is_id_i && index_o[7:0] > 8'd1) |-> resp_o == 32'h0);
  assert_hdr_q_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    QRY_OK && resp_valid_o && $past(!req_is_id_i && index_o == IDX_W'(HDR_FIRST))
    |-> resp_o[7:0] == 8'h51);
endmodule

// File: tb/sim_flash_query_fmt.sv
module sim_flash_query_fmt;
  localparam logic [15:0] MFR  = 16'h0089;
  localparam logic [15:0] DEVC = 16'h8A17;

  typedef struct packed {
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] e2;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_v = 1'b0;
  logic req_id = 1'b0;
  logic [15:0] off = '0;
  int errors = 0;
  int checks = 0;
  logic exp_v = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  logic [12:0] idx0, idx1;
  logic [14:0] idx2;
  logic [7:0]  tb0, tb1, tb2;
  logic        v0, v1, v2;
  logic [31:0] r0, r1, r2;

  function automatic logic [7:0] tbl(input int idx);
    logic [7:0] lo;
    lo = idx[7:0];
    return lo ^ 8'hA5;
  endfunction

  assign tb0 = tbl(int'(idx0));
  assign tb1 = tbl(int'(idx1));
  assign tb2 = tbl(int'(idx2));

  flash_query_fmt #(.OFF_W(16), .BANK_W(4), .DEV_W(1), .MAX_DEV_W(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_is_id_i(req_id),
    .offset_i(off), .index_o(idx0), .table_byte_i(tb0), .mfr_code_i(MFR),
    .dev_code_i(DEVC), .resp_valid_o(v0), .resp_o(r0));
  flash_query_fmt #(.OFF_W(16), .BANK_W(4), .DEV_W(2), .MAX_DEV_W(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_is_id_i(req_id),
    .offset_i(off), .index_o(idx1), .table_byte_i(tb1), .mfr_code_i(MFR),
    .dev_code_i(DEVC), .resp_valid_o(v1), .resp_o(r1));
  flash_query_fmt #(.OFF_W(16), .BANK_W(2), .DEV_W(1), .MAX_DEV_W(1)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_is_id_i(req_id),
    .offset_i(off), .index_o(idx2), .table_byte_i(tb2), .mfr_code_i(MFR),
    .dev_code_i(DEVC), .resp_valid_o(v2), .resp_o(r2));

  function automatic int lg(input int x);
    return (x == 4) ? 2 : (x == 2) ? 1 : 0;
  endfunction

  function automatic logic [31:0] model(input int bw, input int dw, input int mw,
                                        input int o, input bit id);
    int sh, idx;
    logic [31:0] per, res;
    sh  = lg(bw) + lg(mw) - lg(dw);
    idx = o >> sh;
    per = '0;
    if (id) begin
      if ((idx & 255) == 0)      per = {16'h0, MFR};
      else if ((idx & 255) == 1) per = {16'h0, DEVC};
    end else if (dw != mw && dw != 1) per = '0;
    else if (idx >= 'h52) per = '0;
    else begin
      case (idx)
        'h10: per = 32'h51;
        'h11: per = 32'h52;
        'h12: per = 32'h59;
        'h13: per = 32'h01;
        'h14: per = 32'h00;
        default: per = {24'h0, tbl(idx)};
      endcase
    end
    res = '0;
    for (int k = 0; k < bw; k += dw)
      for (int j = 0; j < dw; j++)
        res[(k+j)*8 +: 8] = per[j*8 +: 8];
    return res;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input int o, input bit id);
    exp_t e;
    req_v  = 1'b1;
    req_id = id;
    off    = o[15:0];
    e.e0 = model(4, 1, 2, o, id);
    e.e1 = model(4, 2, 4, o, id);
    e.e2 = model(2, 1, 1, o, id);
    q.push_back(e);
    @(negedge clk);
    req_v = 1'b0;
  endtask

  // bench model of R2 timing
  always @(posedge clk or negedge rst_n)
    if (!rst_n) exp_v <= 1'b0;
    else        exp_v <= req_v;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 valid u0", {31'h0, v0}, {31'h0, exp_v});
      chk("R2 valid u2", {31'h0, v2}, {31'h0, exp_v});
      if (v0) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected response actual=%h expected=none", r0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R3/R4/R5/R8 u0 (4,1,2)", r0, e.e0);
          chk("R6/R7/R8 u1 (4,2,4)", r1, e.e1);
          chk("R4/R7/R8 u2 (2,1,1)", r2, e.e2);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state R2
    chk("R2 reset valid", {29'h0, v0, v1, v2}, 32'h0);
    chk("R2 reset resp u0", r0, 32'h0);
    chk("R2 reset resp u1", r1, 32'h0);
    chk("R2 reset resp u2", r2, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 index shift, combinational
    off = 16'h0288;
    #1;
    chk("R1 index u0", {19'h0, idx0}, 32'h51);
    chk("R1 index u1", {19'h0, idx1}, 32'h51);
    chk("R1 index u2", {17'h0, idx2}, 32'h144);
    @(negedge clk);
    // header bytes R4, x8 repeat R5
    send('h80, 0); send('h88, 0); send('h90, 0); send('h98, 0); send('hA0, 0);
    @(negedge clk);
    // table bytes and range end R3
    send('h100, 0); send('h288, 0); send('h290, 0); send('h7FF8, 0);
    @(negedge clk); @(negedge clk);
    // identifier R8, upper index bits ignored
    send('h0, 1); send('h8, 1); send('h10, 1); send('h18, 1);
    send('h800, 1); send('h808, 1); send('h810, 1);
    @(negedge clk);
    // sweep the whole table and a little beyond
    for (int a = 0; a < 'h2C0; a += 8) send(a, 0);
    @(negedge clk);
    for (int a = 0; a < 'h40; a += 2) send(a, 1);
    repeat (3) @(negedge clk);
    chk("R2 queue drained", q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule